// File: doc/BRIEF.md
# Boolean Share Re-randomiser

This block takes a value held as `NSH` Boolean shares of `W` bits each and returns a fresh set of shares for the same value. The value is the XOR of all the shares. The block adds random words supplied on a side port, and each word goes into an even number of shares, so the recombined value cannot change.

A mode input picks one of two algorithms for each transaction. The linear mode uses `NSH-1` random words. Each word goes into one of the leading shares, and all of them are also folded into the last share. It is cheap and suits masked table recomputation. The pairwise mode uses one random word for every unordered pair of shares, `NSH*(NSH-1)/2` words in total, and adds each word to both shares of its pair. This gives the same result as a share-wise multiplication of the input by a sharing of the constant one, and it composes safely with other masked gadgets.

Transactions enter through a valid/ready handshake and leave through another. The result is registered in a single output stage, so it appears one cycle after acceptance. The random port always has room for the pairwise cost. In linear mode the extra words on that port are not used.

Top module: `mask_refresh`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: For every transfer, the XOR of the `NSH` output shares equals the XOR of the input shares accepted for it, in both modes.
- R3: With `in_mode` = 0 (linear), output share i is input share i XOR random word i for i < `NSH-1`. Output share `NSH-1` is input share `NSH-1` XOR all random words 0..`NSH-2`. Share i occupies bits [i*W +: W] of the share vectors, and random word k occupies bits [k*W +: W] of `in_rand`.
- R4: With `in_mode` = 1 (pairwise), each pair i<j owns random word k = i*NSH − i(i+1)/2 + (j−i−1). Output share m is input share m XOR every word whose pair contains m.
- R5: In linear mode, random words `NSH-1` and above have no effect on the output.
- R6: A transaction accepted at a clock edge is presented on `out_valid`/`out_shares` in the next cycle. With `out_ready` high and no new input, `out_valid` falls one cycle later.
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_shares` holds its value. `in_ready` equals NOT `out_valid` OR `out_ready`.
- R8: Two transactions with identical input shares give different outputs if their random vectors differ in any of the words that the mode uses (linear mode) or differ in exactly one word (pairwise mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input share vector and random words are offered |
| in_ready | output | 1 | Output stage can take a new transaction |
| in_shares | input | NSH*W | Input shares, share i at bits [i*W +: W] |
| in_rand | input | NSH*(NSH-1)/2*W | Random words, word k at bits [k*W +: W] |
| in_mode | input | 1 | 0 = linear refresh, 1 = pairwise refresh |
| out_valid | output | 1 | Refreshed shares are held |
| out_ready | input | 1 | Consumer takes the refreshed shares |
| out_shares | output | NSH*W | Refreshed shares, same layout as the input |

## Verification
The assertions check several properties on every cycle:
- the recombined value is kept across the register;
- the first share in linear mode and the first share in pairwise mode follow their formulas;
- the one-cycle latency holds;
- stalls hold the output and block new input;
- the state is correct when reset is released.

Only the bench scenarios show the following:
- the full per-share equations for each pair index;
- the unused words in linear mode being ignored;
- two refreshes of the same shares with different random words giving different outputs, which compares separate transactions.

// File: rtl/mask_refresh.sv
module mask_refresh #(
  parameter int NSH = 3,
  parameter int W   = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [NSH*W-1:0]              in_shares,
  input  logic [NSH*(NSH-1)/2*W-1:0]    in_rand,
  input  logic                          in_mode,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [NSH*W-1:0]              out_shares
);
  localparam int NLIN = NSH - 1;
  localparam int NRND = NSH * (NSH - 1) / 2;

  logic [W-1:0] a    [NSH];
  logic [W-1:0] r    [NRND];
  logic [W-1:0] lin  [NSH];
  logic [W-1:0] quad [NSH];
  logic [W-1:0] fold;
  logic [NSH*W-1:0] nxt;
  logic [NSH*W-1:0] hold_q;
  logic             vld_q;

  for (genvar g = 0; g < NSH; g++) begin : g_sh
    assign a[g] = in_shares[g*W +: W];
    if (g < NLIN) begin : g_lead
      assign lin[g] = a[g] ^ r[g];
    end else begin : g_last
      assign lin[g] = a[g] ^ fold;
    end
    assign nxt[g*W +: W] = in_mode ? quad[g] : lin[g];
  end

  for (genvar k = 0; k < NRND; k++) begin : g_rw
    assign r[k] = in_rand[k*W +: W];
  end

  always_comb begin
    fold = '0;
    for (int k = 0; k < NLIN; k++) fold = fold ^ r[k];
  end

  always_comb begin
    int k;
    k = 0;
    for (int i = 0; i < NSH; i++) quad[i] = a[i];
    for (int i = 0; i < NSH; i++) begin
      for (int j = i + 1; j < NSH; j++) begin
        quad[i] = quad[i] ^ r[k];
        quad[j] = quad[j] ^ r[k];
        k++;
      end
    end
  end

  assign in_ready = !vld_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      hold_q <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) hold_q <= nxt;
    end
  end

  assign out_valid  = vld_q;
  assign out_shares = hold_q;
endmodule

// File: rtl/mask_refresh_chk.sv
module mask_refresh_chk #(
  parameter int NSH = 3,
  parameter int W   = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic [NSH*W-1:0]           in_shares,
  input logic [NSH*(NSH-1)/2*W-1:0] in_rand,
  input logic                       in_mode,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [NSH*W-1:0]           out_shares
);
  logic [W-1:0] in_x, out_x, lead_x;
  logic         take;

  assign take = in_valid && in_ready;

  always_comb begin
    in_x = '0;
    out_x = '0;
    lead_x = '0;
    for (int i = 0; i < NSH; i++) begin
      in_x  = in_x ^ in_shares[i*W +: W];
      out_x = out_x ^ out_shares[i*W +: W];
    end
    for (int k = 0; k < NSH - 1; k++) lead_x = lead_x ^ in_rand[k*W +: W];
  end

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && in_ready));

  p_value_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (out_x == $past(in_x)));

  p_lin_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_mode) |=> (out_shares[W-1:0] == $past(in_shares[W-1:0] ^ in_rand[W-1:0])));

  p_pair_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_mode) |=> (out_shares[W-1:0] == $past(in_shares[W-1:0] ^ lead_x)));

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_shares)));

  p_stall_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind mask_refresh mask_refresh_chk #(.NSH(NSH), .W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_shares(in_shares), .in_rand(in_rand), .in_mode(in_mode),
  .out_valid(out_valid), .out_ready(out_ready), .out_shares(out_shares)
);

// File: tb/mask_refresh_tb_top.sv
module mask_refresh_tb_top;
  localparam int N  = 4;
  localparam int W  = 8;
  localparam int NR = N * (N - 1) / 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n, in_valid, in_ready, in_mode, out_valid, out_ready;
  logic [N*W-1:0]  in_shares, out_shares;
  logic [NR*W-1:0] in_rand;

  mask_refresh #(.NSH(N), .W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_shares(in_shares), .in_rand(in_rand), .in_mode(in_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_shares(out_shares)
  );

  typedef struct {
    logic [N*W-1:0] exp;
    logic [N*W-1:0] inp;
    string          tag;
  } item_t;

  item_t          sb[$];
  logic [N*W-1:0] got[$];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] xr(input logic [N*W-1:0] v);
    logic [W-1:0] x = '0;
    for (int i = 0; i < N; i++) x ^= v[i*W +: W];
    return x;
  endfunction

  function automatic logic [N*W-1:0] model(input logic [N*W-1:0] sh, input logic [NR*W-1:0] rn, input logic md);
    logic [N*W-1:0] c = sh;
    for (int i = 0; i < N; i++) begin
      if (!md) begin
        if (i < N - 1) c[i*W +: W] ^= rn[i*W +: W];
        else for (int k = 0; k < N - 1; k++) c[i*W +: W] ^= rn[k*W +: W];
      end else begin
        for (int j = 0; j < N; j++) begin
          if (j != i) begin
            int lo, hi, k;
            lo = (i < j) ? i : j;
            hi = (i < j) ? j : i;
            k = lo * N - lo * (lo + 1) / 2 + (hi - lo - 1);
            c[i*W +: W] ^= rn[k*W +: W];
          end
        end
      end
    end
    return c;
  endfunction

  function automatic logic [N*W-1:0] rsh();
    return N*W'($urandom());
  endfunction

  function automatic logic [NR*W-1:0] rrn();
    return NR*W'({$urandom(), $urandom()});
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R6 output with no pending transaction", out_shares, '0);
      end else begin
        item_t it;
        it = sb.pop_front();
        chk(out_shares == it.exp, it.tag, out_shares, it.exp);
        chk(xr(out_shares) == xr(it.inp), "R2 recombined value", {{(N-1)*W{1'b0}}, xr(out_shares)}, {{(N-1)*W{1'b0}}, xr(it.inp)});
        got.push_back(out_shares);
      end
    end
  end

  task automatic send(input logic [N*W-1:0] sh, input logic [NR*W-1:0] rn, input logic md, input string tag);
    bit acc;
    item_t it;
    acc = 0;
    while (!acc) begin
      @(negedge clk);
      in_valid = 1'b1; in_shares = sh; in_rand = rn; in_mode = md;
      acc = in_ready;
      @(posedge clk);
    end
    it.exp = model(sh, rn, md); it.inp = sh; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    idle();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N*W-1:0] s, snap;
    logic [NR*W-1:0] ra, rb;
    int base;
    rst_n = 0; in_valid = 0; in_mode = 0; in_shares = '0; in_rand = '0; out_ready = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_valid && in_ready, "R1 state during reset", {out_valid, in_ready}, 2'b01);
    rst_n = 1;
    @(negedge clk);
    chk(!out_valid && in_ready, "R1 state after release", {out_valid, in_ready}, 2'b01);

    for (int t = 0; t < 6; t++) send(rsh(), rrn(), 1'b0, "R3 linear refresh");
    send(32'h0123_4567, '0, 1'b0, "R3 linear zero randomness");
    for (int t = 0; t < 6; t++) send(rsh(), rrn(), 1'b1, "R4 pairwise refresh");
    for (int k = 0; k < NR; k++) begin
      logic [NR*W-1:0] one = '0;
      one[k*W +: W] = 8'h5A + 8'(k);
      send(32'hA5C3_0F96, one, 1'b1, "R4 single pair word");
    end
    drain();

    s = rsh(); ra = rrn();
    rb = ra; rb[NR*W-1:(N-1)*W] = ~ra[NR*W-1:(N-1)*W];
    send(s, ra, 1'b0, "R5 linear upper words A");
    send(s, rb, 1'b0, "R5 linear upper words flipped");
    drain();

    send(rsh(), rrn(), 1'b0, "R6 latency item");
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid, "R6 valid one cycle after accept", N*W'(out_valid), 1);
    @(negedge clk);
    chk(!out_valid, "R6 valid drops with no new input", N*W'(out_valid), 0);

    @(posedge clk); #2 out_ready = 0;
    send(rsh(), rrn(), 1'b1, "R7 stalled item");
    @(negedge clk);
    in_valid = 1'b1; in_shares = rsh(); in_rand = rrn();
    snap = out_shares;
    chk(!in_ready, "R7 in_ready low while stalled", N*W'(in_ready), 0);
    for (int t = 0; t < 3; t++) begin
      @(negedge clk);
      chk(out_valid && out_shares == snap, "R7 output held during stall", out_shares, snap);
      chk(!in_ready, "R7 input blocked during stall", N*W'(in_ready), 0);
    end
    in_valid = 1'b0;
    @(posedge clk); #2 out_ready = 1;
    send(rsh(), rrn(), 1'b1, "R7 item after stall");
    drain();

    s = rsh(); ra = rrn(); rb = ra; rb[W-1:0] = ra[W-1:0] ^ 8'h01;
    base = got.size();
    send(s, ra, 1'b0, "R8 linear first");
    send(s, rb, 1'b0, "R8 linear second");
    rb = ra; rb[4*W +: W] = ra[4*W +: W] ^ 8'h80;
    send(s, ra, 1'b1, "R8 pairwise first");
    send(s, rb, 1'b1, "R8 pairwise second");
    drain();
    chk(got[base] != got[base+1], "R8 linear outputs differ", got[base], ~got[base+1]);
    chk(got[base+2] != got[base+3], "R8 pairwise outputs differ", got[base+2], ~got[base+3]);

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule